// File: doc/BRIEF.md
# Signed Remainder and Modulus Divider

This block divides one signed two's-complement integer by another and returns both common remainder conventions from a single pass. The truncated remainder follows the dividend's sign. The floored modulus follows the divisor's sign. The quotient, truncated toward zero, is available as a side output. Inside, a shift-subtract loop works on operand magnitudes and finds one quotient bit per clock. A combinational sign stage then builds the remainder, the modulus and the quotient from the magnitude results.

Operands enter through a valid/ready handshake. An operand pair is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole calculation, so a producer holds `in_valid` and its operands until the block is ready again. Only one operation is in flight at a time. Results leave with a one-cycle `done` pulse and have no back-pressure. The consumer must take them in that cycle or read the held outputs later, because the outputs keep their values until the next `done`. A zero divisor does not stall the block: it completes with the normal timing and raises a flag.

Top module: `signed_rem_mod`

## Requirements
- R1: An operand pair is accepted on a rising edge where `in_valid` and `in_ready` are both high. `busy` is high from the next cycle until the result is presented. `in_ready` is high exactly when `busy` is low.
- R2: `done` is a single-cycle pulse. It is high in the cycle that follows the W+1-th rising edge after the accepting edge, for every operand pair. `busy` is low in that cycle, and a new pair may be accepted in it.
- R3: `rem_o` equals X minus trunc(X/Y)·Y. It is zero or carries the sign of X, and its magnitude is below |Y|.
- R4: `mod_o` is zero or carries the sign of Y, and its magnitude is below |Y|. It equals `rem_o` + Y when `rem_o` is nonzero and its sign differs from Y's sign; otherwise it equals `rem_o`.
- R5: With W=8 the block returns rem/mod = 3/3 for 8,5; −3/2 for −8,5; 3/−2 for 8,−5; and −3/−3 for −8,−5.
- R6: `quo_o` is X/Y truncated toward zero, taken modulo 2^W. The one overflowing case, −2^(W−1) divided by −1, returns −2^(W−1).
- R7: The most negative dividend is divided correctly, with no overflow in the magnitude path. For example, −128 rem 7 = −2 and −128 mod 7 = 5.
- R8: With Y = 0, `div_zero` is high together with `done`, and `rem_o`, `mod_o` and `quo_o` are all zero. For any nonzero Y, `div_zero` is low with `done`.
- R9: `in_valid` raised while `busy` is high is not accepted. It produces no additional `done`, and it leaves the result of the running operation unchanged.
- R10: `rem_o`, `mod_o`, `quo_o` and `div_zero` change only in a cycle where `done` is high.
- R11: After reset, `busy` and `done` are low, `in_ready` is high, and all result outputs and `div_zero` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can accept an operand pair |
| in_x | input | W | Dividend, signed |
| in_y | input | W | Divisor, signed |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result strobe |
| rem_o | output | W | Truncated remainder, signed |
| mod_o | output | W | Floored modulus, signed |
| quo_o | output | W | Quotient truncated toward zero, signed |
| div_zero | output | 1 | Divisor was zero for the presented result |

## Verification
A wrong step counter or state sequence shows first in the timing of `done`. The pulse arrives early, late, twice or not at all, and this is visible on the very first operation after reset. A wrong partial-remainder or quotient bit shows up in the magnitude of `rem_o` or `quo_o` at the next `done`. A wrongly captured sign, or a wrong correction condition, affects only operands of mixed sign or a negative dividend. Such faults appear on the first such pair as a sign or offset error in `rem_o` or `mod_o`, while same-sign positive pairs still look correct. For that reason the stimulus mixes all four sign combinations from the start, along with zero divisors and the most negative dividend.

// File: rtl/rm_pkg.sv
package rm_pkg;
  // Control sequence of the divider: wait, iterate, fix signs and present
  typedef enum logic [1:0] {
    RM_IDLE = 2'd0,
    RM_CALC = 2'd1,
    RM_FIX  = 2'd2
  } rm_state_e;
endpackage

// File: rtl/rm_magnitude.sv
// Absolute value of a signed W-bit operand, returned as unsigned W bits.
// -2^(W-1) maps to 2^(W-1), which still fits in W unsigned bits.
module rm_magnitude #(
  parameter int W = 8
) (
  input  logic [W-1:0] value,
  output logic [W-1:0] mag
);
  always_comb begin
    if (value[W-1]) mag = ~value + W'(1);
    else            mag = value;
  end
endmodule

// File: rtl/rm_core.sv
// Restoring shift-subtract loop on magnitudes, one quotient bit per step.
module rm_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] rem_mag,
  output logic [W-1:0] quo_mag
);
  logic [W-1:0] part;     // partial remainder, always below divisor
  logic [W-1:0] quo;      // dividend bits shift out, quotient bits shift in
  logic [W-1:0] dvs;
  logic [W:0]   shifted;
  logic [W-1:0] diff;
  logic         fits;

  always_comb begin
    shifted = {part, quo[W-1]};
    fits    = shifted >= {1'b0, dvs};
    // true difference is below dvs <= 2^(W-1), so W bits hold it
    diff    = shifted[W-1:0] - dvs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part <= '0;
      quo  <= '0;
      dvs  <= '0;
    end else if (load) begin
      part <= '0;
      quo  <= dividend;
      dvs  <= divisor;
    end else if (step) begin
      part <= fits ? diff : shifted[W-1:0];
      quo  <= {quo[W-2:0], fits};
    end
  end

  assign rem_mag = part;
  assign quo_mag = quo;
endmodule

// File: rtl/rm_fixup.sv
// Sign restoration: remainder follows dividend, modulus follows divisor.
module rm_fixup #(
  parameter int W = 8
) (
  input  logic [W-1:0] rem_mag,
  input  logic [W-1:0] quo_mag,
  input  logic         x_neg,
  input  logic [W-1:0] divisor,
  input  logic         zero,
  output logic [W-1:0] rem_v,
  output logic [W-1:0] mod_v,
  output logic [W-1:0] quo_v
);
  logic [W-1:0] r_s;
  logic [W-1:0] q_s;
  logic         q_neg;
  logic         adjust;

  always_comb begin
    q_neg  = x_neg ^ divisor[W-1];
    r_s    = x_neg ? (~rem_mag + W'(1)) : rem_mag;
    q_s    = q_neg ? (~quo_mag + W'(1)) : quo_mag;
    // opposite signs: shift remainder by one divisor toward the divisor's sign
    adjust = (r_s != '0) && (r_s[W-1] != divisor[W-1]);
    if (zero) begin
      rem_v = '0;
      mod_v = '0;
      quo_v = '0;
    end else begin
      rem_v = r_s;
      mod_v = adjust ? (r_s + divisor) : r_s;
      quo_v = q_s;
    end
  end
endmodule

// File: rtl/signed_rem_mod.sv
module signed_rem_mod
  import rm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] mod_o,
  output logic [W-1:0] quo_o,
  output logic         div_zero
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  rm_state_e    state;
  logic [CW-1:0] cnt;
  logic         x_neg;
  logic [W-1:0] y_hold;
  logic         zero_hold;
  logic         accept;
  logic [W-1:0] x_mag, y_mag;
  logic [W-1:0] rem_mag, quo_mag;
  logic [W-1:0] fx_rem, fx_mod, fx_quo;

  assign in_ready = (state == RM_IDLE);
  assign busy     = (state != RM_IDLE);
  assign accept   = in_valid && (state == RM_IDLE);

  rm_magnitude #(.W(W)) u_xmag (.value(in_x), .mag(x_mag));
  rm_magnitude #(.W(W)) u_ymag (.value(in_y), .mag(y_mag));

  rm_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .step     (state == RM_CALC),
    .dividend (x_mag),
    .divisor  (y_mag),
    .rem_mag  (rem_mag),
    .quo_mag  (quo_mag)
  );

  rm_fixup #(.W(W)) u_fix (
    .rem_mag (rem_mag),
    .quo_mag (quo_mag),
    .x_neg   (x_neg),
    .divisor (y_hold),
    .zero    (zero_hold),
    .rem_v   (fx_rem),
    .mod_v   (fx_mod),
    .quo_v   (fx_quo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RM_IDLE;
      cnt       <= '0;
      x_neg     <= 1'b0;
      y_hold    <= '0;
      zero_hold <= 1'b0;
      done      <= 1'b0;
      rem_o     <= '0;
      mod_o     <= '0;
      quo_o     <= '0;
      div_zero  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        RM_IDLE: begin
          if (accept) begin
            state     <= RM_CALC;
            cnt       <= '0;
            x_neg     <= in_x[W-1];
            y_hold    <= in_y;
            zero_hold <= (in_y == '0);
          end
        end
        RM_CALC: begin
          if (cnt == LAST) state <= RM_FIX;
          else             cnt   <= cnt + CW'(1);
        end
        RM_FIX: begin
          rem_o    <= fx_rem;
          mod_o    <= fx_mod;
          quo_o    <= fx_quo;
          div_zero <= zero_hold;
          done     <= 1'b1;
          state    <= RM_IDLE;
        end
        default: state <= RM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rm_chk.sv
module rm_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         accept,
  input logic         busy,
  input logic         done,
  input logic         div_zero,
  input logic         x_msb,
  input logic         y_msb,
  input logic [W-1:0] rem_o,
  input logic [W-1:0] mod_o,
  input logic [W-1:0] quo_o
);
  localparam int LW = $clog2(W + 3) + 1;

  logic          xs, ys;
  logic [LW-1:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs  <= 1'b0;
      ys  <= 1'b0;
      lat <= '0;
    end else if (accept) begin
      xs  <= x_msb;
      ys  <= y_msb;
      lat <= LW'(1);
    end else if (busy) begin
      lat <= lat + LW'(1);
    end
  end

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((lat == LW'(W + 2)) && !busy));

  // R2
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  rem_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (rem_o != '0)) |-> (rem_o[W-1] == xs));

  // R4
  mod_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (mod_o != '0)) |-> (mod_o[W-1] == ys));

  // R8
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> ((rem_o == '0) && (mod_o == '0) && (quo_o == '0)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(rem_o) && $stable(mod_o) && $stable(quo_o) && $stable(div_zero)));
endmodule

bind signed_rem_mod rm_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .accept   (in_valid && in_ready),
  .busy     (busy),
  .done     (done),
  .div_zero (div_zero),
  .x_msb    (in_x[W-1]),
  .y_msb    (in_y[W-1]),
  .rem_o    (rem_o),
  .mod_o    (mod_o),
  .quo_o    (quo_o)
);

// File: tb/sim_signed_rem_mod.sv
module sim_signed_rem_mod;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         in_valid = 1'b0;
  logic [W-1:0] in_x = '0;
  logic [W-1:0] in_y = '0;
  logic         in_ready, busy, done, div_zero;
  logic [W-1:0] rem_o, mod_o, quo_o;

  signed_rem_mod #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .busy(busy), .done(done),
    .rem_o(rem_o), .mod_o(mod_o), .quo_o(quo_o), .div_zero(div_zero)
  );

  typedef struct {
    logic [W-1:0] r;
    logic [W-1:0] m;
    logic [W-1:0] q;
    logic         dz;
    int           due;
    string        tag;
  } exp_t;

  exp_t sbq[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  logic [W-1:0] last_r = '0, last_m = '0, last_q = '0;
  logic         last_dz = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Drive one operand pair and queue its expected result.
  task automatic send(input int x, input int y, input string tag);
    exp_t e;
    int r, m, q;
    @(negedge clk);
    in_valid = 1'b1;
    in_x = x[W-1:0];
    in_y = y[W-1:0];
    while (!in_ready) @(negedge clk);
    if (y == 0) begin
      r = 0; m = 0; q = 0; e.dz = 1'b1;
    end else begin
      r = x % y;
      m = ((x % y) + y) % y;
      q = x / y;
      e.dz = 1'b0;
    end
    e.r = r[W-1:0];
    e.m = m[W-1:0];
    e.q = q[W-1:0];
    e.due = cyc + W + 2;
    e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    // R1: accepted pair makes the block busy and not ready
    chk(busy && !in_ready, "R1", "busy after accept", int'(busy), 1);
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done) begin
        exp_t e;
        chk(!busy, "R2", "busy low with done", int'(busy), 0);
        if (sbq.size() == 0) begin
          chk(1'b0, "R9", "done with no accepted pair", 1, 0);
        end else begin
          e = sbq.pop_front();
          chk(cyc == e.due, "R2", {e.tag, " done cycle"}, cyc, e.due);
          chk(rem_o == e.r, "R3", {e.tag, " rem"},
              int'($signed(rem_o)), int'($signed(e.r)));
          chk(mod_o == e.m, "R4", {e.tag, " mod"},
              int'($signed(mod_o)), int'($signed(e.m)));
          chk(quo_o == e.q, "R6", {e.tag, " quo"},
              int'($signed(quo_o)), int'($signed(e.q)));
          chk(div_zero == e.dz, "R8", {e.tag, " div_zero"},
              int'(div_zero), int'(e.dz));
        end
        last_r = rem_o; last_m = mod_o; last_q = quo_o; last_dz = div_zero;
      end else begin
        // R10: outputs hold between done pulses
        chk((rem_o == last_r) && (mod_o == last_m) && (quo_o == last_q) &&
            (div_zero == last_dz), "R10", "held outputs",
            int'($signed(rem_o)), int'($signed(last_r)));
      end
    end
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!busy, "R11", "busy", int'(busy), 0);
    chk(!done, "R11", "done", int'(done), 0);
    chk(in_ready, "R11", "in_ready", int'(in_ready), 1);
    chk((rem_o == '0) && (mod_o == '0) && (quo_o == '0) && !div_zero,
        "R11", "outputs zero", int'($signed(rem_o)), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: the four sign combinations
    send(8, 5, "R5");
    send(-8, 5, "R5");
    send(8, -5, "R5");
    send(-8, -5, "R5");

    // R7: most negative dividend
    send(-128, 7, "R7");
    send(-128, -7, "R7");
    send(-128, 1, "R7");
    send(-128, -128, "R7");
    // R6: overflowing quotient wraps
    send(-128, -1, "R6");
    send(127, -128, "R6");
    send(15, -5, "R6");
    send(0, -3, "R6");

    // R8: zero divisor
    send(7, 0, "R8");
    send(-128, 0, "R8");
    send(5, 3, "R8");

    // R9: valid pulse while busy is not taken
    send(100, 7, "R9");
    @(negedge clk);
    chk(!in_ready, "R9", "in_ready while busy", int'(in_ready), 0);
    in_valid = 1'b1; in_x = 8'd99; in_y = 8'd4;
    @(negedge clk);
    in_valid = 1'b0;
    while (sbq.size() != 0) @(negedge clk);
    repeat (2 * W + 4) @(negedge clk);
    chk(rem_o == 8'd2 && quo_o == 8'd14, "R9", "result of running op kept",
        int'($signed(rem_o)), 2);

    // R3 R4: random pairs, back to back
    for (int i = 0; i < 300; i++) begin
      int x, y;
      x = int'($urandom_range(0, 255)) - 128;
      y = int'($urandom_range(0, 255)) - 128;
      if ((i % 37) == 0) y = 0;
      send(x, y, "R3R4rand");
    end

    while (sbq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule